// File: doc/BRIEF.md
# Stride-Serial Range Match Pipeline

This block decides whether a packet-header field lies inside one rule's inclusive range `[lo, hi]`. It does not compare the whole field at once. A systolic chain of processing elements handles the field a few bits at a time, starting with the most significant bits. Each element compares one stride of the header with the same stride of both bounds. It then registers the partial outcome, the header and a valid flag for the next element.

One header can enter on every clock cycle. Each match result appears a fixed number of cycles later, equal to the number of stages. Prefix rules and exact-value rules are written as ranges, so one datapath covers all three kinds of match.

Each element reads its stride of the bounds only while the outcome is still open. Once an earlier stride has placed the header strictly inside or outside a bound, the downstream elements keep their read enable low. Placing high-entropy fields in the earliest stages lets more elements stay idle.

Top module: `range_match_pipe`

## Requirements
- R1: `out_match` is 1 exactly when `lo <= x <= hi` for the header `x` that entered NSTG = W/S cycles earlier with `in_valid` high (W=16, S=4, NSTG=4 by default).
- R2: A new header is accepted on every cycle, and results leave in the same order, one per cycle, with no bubbles added.
- R3: Both bounds are inclusive: a header equal to `lo` or to `hi` matches.
- R4: A single-value range (`lo == hi`) matches that value only.
- R5: An empty range (`lo > hi`) matches no header.
- R6: An invalid slot (`in_valid` low) gives `out_valid` 0 and `out_match` 0 when it leaves the pipeline, and it keeps every stage enable low while it passes through.
- R7: `stage_en[k]` is high exactly when the header held by stage k is valid and strides 0..k-1 of that header are still equal to the same strides of `lo` or of `hi`. Stride 0 is the most significant S bits, so stage 0 is always enabled for a valid header.
- R8: A stage is never enabled unless the stage before it was enabled one cycle earlier.
- R9: After reset, `out_valid`, `out_match` and every bit of `stage_en` are 0.
- R10: A prefix rule written as `lo` = the prefix followed by all zeros and `hi` = the prefix followed by all ones matches exactly the headers that carry that prefix.
- R11: A pulse on `cfg_we` loads `cfg_lo` and `cfg_hi` at the clock edge. The new bounds apply to every header that enters on the following cycle or later.
- R12: A partial outcome that is already GREATER (encoding 01) or LESS (10) passes to the next stage unchanged. Only the EQUAL state (00) is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| cfg_we | input | 1 | Loads both range bounds |
| cfg_lo | input | W | Lower bound, inclusive |
| cfg_hi | input | W | Upper bound, inclusive |
| in_valid | input | 1 | Header slot carries a lookup |
| in_hdr | input | W | Header field value |
| out_valid | output | 1 | Result slot carries a lookup |
| out_match | output | 1 | Header lay inside the range |
| stage_en | output | W/S | Bound-read enable of each stage |

## Verification
Two functions act in the same cycle on every clock. The matching of one header at the output overlaps with the gating of the headers that follow it in the upper stages. A back-to-back stream mixes headers that settle at the first stride with headers that stay equal to a bound down to the last stride. In each cycle the bench compares all the stage enables against the stride prefixes of the headers in flight, and it compares the output against `lo <= x <= hi` for the header that entered NSTG cycles earlier. Bubbles in the stream show that gating and valid travel with their own slot and do not leak into neighbouring slots.

// File: rtl/rm_pkg.sv
package rm_pkg;
  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_GT = 2'b01,
    CMP_LT = 2'b10
  } cmp_t;
endpackage

// File: rtl/rm_bound_store.sv
module rm_bound_store #(
  parameter int S = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [S-1:0] wr_lo,
  input  logic [S-1:0] wr_hi,
  input  logic         rd_en,
  output logic [S-1:0] rd_lo,
  output logic [S-1:0] rd_hi
);
  logic [S-1:0] lo_q, hi_q;
  logic [S-1:0] lo_d, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (wr_en) begin
      lo_d = wr_lo;
      hi_d = wr_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  // gated read port: no toggling while the stage is disabled
  assign rd_lo = rd_en ? lo_q : '0;
  assign rd_hi = rd_en ? hi_q : '0;
endmodule

// File: rtl/rm_stride_pe.sv
module rm_stride_pe
  import rm_pkg::*;
#(
  parameter int W   = 16,
  parameter int S   = 4,
  parameter int IDX = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_i,
  input  logic [W-1:0] hdr_i,
  input  cmp_t         lo_st_i,
  input  cmp_t         hi_st_i,
  input  logic [S-1:0] bnd_lo,
  input  logic [S-1:0] bnd_hi,
  output logic         rd_en,
  output logic         v_o,
  output logic [W-1:0] hdr_o,
  output cmp_t         lo_st_o,
  output cmp_t         hi_st_o
);
  localparam int MSB = W - 1 - IDX * S;

  logic [S-1:0] strd;
  cmp_t         lo_d, hi_d;
  logic         armed;

  assign strd  = hdr_i[MSB -: S];
  assign rd_en = v_i && ((lo_st_i == CMP_EQ) || (hi_st_i == CMP_EQ));

  always_comb begin
    lo_d = lo_st_i;
    hi_d = hi_st_i;
    if (rd_en && lo_st_i == CMP_EQ) begin
      if (strd > bnd_lo)      lo_d = CMP_GT;
      else if (strd < bnd_lo) lo_d = CMP_LT;
    end
    if (rd_en && hi_st_i == CMP_EQ) begin
      if (strd > bnd_hi)      hi_d = CMP_GT;
      else if (strd < bnd_hi) hi_d = CMP_LT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o     <= 1'b0;
      hdr_o   <= '0;
      lo_st_o <= CMP_EQ;
      hi_st_o <= CMP_EQ;
      armed   <= 1'b0;
    end else begin
      v_o     <= v_i;
      hdr_o   <= hdr_i;
      lo_st_o <= lo_d;
      hi_st_o <= hi_d;
      armed   <= 1'b1;
    end
  end

  AST_LO_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(lo_st_i) != CMP_EQ) |-> (lo_st_o == $past(lo_st_i))); // R12
  AST_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(hi_st_i) != CMP_EQ) |-> (hi_st_o == $past(hi_st_i))); // R12
  AST_VALID_SHIFT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    v_o == $past(v_i)); // R2
endmodule

// File: rtl/range_match_pipe.sv
module range_match_pipe
  import rm_pkg::*;
#(
  parameter int W = 16,
  parameter int S = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [W-1:0]   cfg_lo,
  input  logic [W-1:0]   cfg_hi,
  input  logic           in_valid,
  input  logic [W-1:0]   in_hdr,
  output logic           out_valid,
  output logic           out_match,
  output logic [W/S-1:0] stage_en
);
  localparam int NSTG = W / S;

  logic         rst_meta, rst_s;
  logic         armed;
  logic         v_c   [NSTG+1];
  logic [W-1:0] hdr_c [NSTG+1];
  cmp_t         lo_c  [NSTG+1];
  cmp_t         hi_c  [NSTG+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign v_c[0]   = in_valid;
  assign hdr_c[0] = in_hdr;
  assign lo_c[0]  = CMP_EQ;
  assign hi_c[0]  = CMP_EQ;

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    localparam int MSB = W - 1 - k * S;
    logic [S-1:0] b_lo, b_hi;

    rm_bound_store #(.S(S)) u_bnd (
      .clk   (clk),
      .rst_n (rst_s),
      .wr_en (cfg_we),
      .wr_lo (cfg_lo[MSB -: S]),
      .wr_hi (cfg_hi[MSB -: S]),
      .rd_en (stage_en[k]),
      .rd_lo (b_lo),
      .rd_hi (b_hi)
    );

    rm_stride_pe #(.W(W), .S(S), .IDX(k)) u_pe (
      .clk     (clk),
      .rst_n   (rst_s),
      .v_i     (v_c[k]),
      .hdr_i   (hdr_c[k]),
      .lo_st_i (lo_c[k]),
      .hi_st_i (hi_c[k]),
      .bnd_lo  (b_lo),
      .bnd_hi  (b_hi),
      .rd_en   (stage_en[k]),
      .v_o     (v_c[k+1]),
      .hdr_o   (hdr_c[k+1]),
      .lo_st_o (lo_c[k+1]),
      .hi_st_o (hi_c[k+1])
    );

    if (k > 0) begin : g_chain
      AST_EN_CHAIN: assert property (@(posedge clk) disable iff (!rst_s || !armed)
        stage_en[k] |-> $past(stage_en[k-1])); // R8
    end
  end

  assign out_valid = v_c[NSTG];
  assign out_match = v_c[NSTG] && (lo_c[NSTG] != CMP_LT) && (hi_c[NSTG] != CMP_GT);

  AST_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_s)
    out_match |-> out_valid); // R6
  AST_IDLE_NO_EN: assert property (@(posedge clk) disable iff (!rst_s)
    !in_valid |-> !stage_en[0]); // R6
endmodule

// File: tb/range_match_pipe_tb.sv
module range_match_pipe_tb;
  localparam int W = 16;
  localparam int S = 4;
  localparam int NSTG = W / S;
  localparam int MAXN = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_we;
  logic [W-1:0]    cfg_lo, cfg_hi;
  logic            in_valid;
  logic [W-1:0]    in_hdr;
  logic            out_valid, out_match;
  logic [NSTG-1:0] stage_en;

  int tests = 0;
  int fails = 0;

  logic [W-1:0] st_hdr [MAXN];
  logic         st_v   [MAXN];

  always #5 clk = ~clk;

  range_match_pipe #(.W(W), .S(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .in_valid(in_valid), .in_hdr(in_hdr), .out_valid(out_valid),
    .out_match(out_match), .stage_en(stage_en)
  );

  function automatic logic exp_en(logic [W-1:0] x, logic v, logic [W-1:0] lo,
                                  logic [W-1:0] hi, int k);
    int sh;
    if (!v) return 1'b0;
    if (k == 0) return 1'b1;
    sh = W - k * S;
    return ((x >> sh) == (lo >> sh)) || ((x >> sh) == (hi >> sh));
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // loads the range, then streams st_hdr/st_v[0..n-1] back to back and checks every cycle
  task automatic run_stream(input logic [W-1:0] lo, input logic [W-1:0] hi,
                            input int n, input string rq);
    @(negedge clk);
    cfg_we = 1'b1; cfg_lo = lo; cfg_hi = hi;
    for (int j = 0; j < n + NSTG; j++) begin
      logic [NSTG-1:0] een;
      @(negedge clk);
      cfg_we = 1'b0;
      in_valid = (j < n) ? st_v[j] : 1'b0;
      in_hdr   = (j < n) ? st_hdr[j] : '0;
      #1;
      een = '0;
      for (int k = 0; k < NSTG; k++) begin
        int idx = j - k;
        if (idx >= 0 && idx < n) een[k] = exp_en(st_hdr[idx], st_v[idx], lo, hi, k);
      end
      check({rq, " R7 enables"}, 32'(stage_en), 32'(een));
      if (j >= NSTG) begin
        int idx = j - NSTG;
        logic em;
        em = st_v[idx] && (lo <= st_hdr[idx]) && (st_hdr[idx] <= hi);
        check({rq, " R1 valid"}, 32'(out_valid), 32'(st_v[idx]));
        check({rq, " R1 match"}, 32'(out_match), 32'(em));
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_lo = '0; cfg_hi = '0; in_valid = 1'b0; in_hdr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R9 out_valid", 32'(out_valid), 0);
    check("R9 out_match", 32'(out_match), 0);
    check("R9 stage_en", 32'(stage_en), 0);
  endtask

  task automatic t_random_ranges();
    for (int r = 0; r < 20; r++) begin
      logic [W-1:0] a, b, lo, hi;
      a = W'($urandom); b = W'($urandom);
      lo = (a < b) ? a : b; hi = (a < b) ? b : a;
      for (int i = 0; i < 32; i++) begin
        st_v[i] = 1'b1;
        case (i % 4)
          0: st_hdr[i] = W'($urandom);
          1: st_hdr[i] = lo + W'($urandom_range(0, 3)) - W'(1);
          2: st_hdr[i] = hi + W'($urandom_range(0, 3)) - W'(1);
          default: st_hdr[i] = {lo[W-1 -: S], W'($urandom) >> S};
        endcase
      end
      run_stream(lo, hi, 32, "R2 R11 random");
    end
  endtask

  task automatic t_bounds();
    st_hdr[0] = 16'h3A70; st_hdr[1] = 16'h3A6F; st_hdr[2] = 16'hC015;
    st_hdr[3] = 16'hC016; st_hdr[4] = 16'h3A71; st_hdr[5] = 16'hC014;
    for (int i = 0; i < 6; i++) st_v[i] = 1'b1;
    run_stream(16'h3A70, 16'hC015, 6, "R3 inclusive");
    st_hdr[0] = 16'h0000; st_hdr[1] = 16'hFFFF;
    run_stream(16'h0000, 16'hFFFF, 2, "R3 full span");
  endtask

  task automatic t_single();
    st_hdr[0] = 16'h5A5A; st_hdr[1] = 16'h5A5B; st_hdr[2] = 16'h5A59;
    st_hdr[3] = 16'h4A5A; st_hdr[4] = 16'h5A5A;
    for (int i = 0; i < 5; i++) st_v[i] = 1'b1;
    run_stream(16'h5A5A, 16'h5A5A, 5, "R4 single");
  endtask

  task automatic t_empty();
    for (int i = 0; i < 8; i++) begin
      st_v[i] = 1'b1; st_hdr[i] = 16'h2000 + W'(i * 16'h0400);
    end
    st_hdr[7] = 16'h3000;
    run_stream(16'h3000, 16'h2FFF, 8, "R5 empty");
  endtask

  task automatic t_bubbles();
    for (int i = 0; i < 24; i++) begin
      st_v[i] = (i % 3) != 1;
      st_hdr[i] = (i % 2 == 0) ? 16'h7770 : 16'h7777;
    end
    run_stream(16'h7770, 16'h7777, 24, "R6 bubbles");
  endtask

  task automatic t_prefix();
    for (int i = 0; i < 16; i++) begin
      st_v[i] = 1'b1;
      st_hdr[i] = {8'hA5 ^ 8'(i % 2), 8'($urandom)};
    end
    run_stream(16'hA500, 16'hA5FF, 16, "R10 prefix");
  endtask

  task automatic t_sticky();
    // headers settle at stride 0, 1, 2 and 3 to check the forwarded state (R12)
    st_hdr[0] = 16'h9000; st_hdr[1] = 16'h1FFF; st_hdr[2] = 16'h4300;
    st_hdr[3] = 16'h4230; st_hdr[4] = 16'h4200; st_hdr[5] = 16'h42FF;
    st_hdr[6] = 16'h4244; st_hdr[7] = 16'h4245;
    for (int i = 0; i < 8; i++) st_v[i] = 1'b1;
    run_stream(16'h4244, 16'h4245, 8, "R12 sticky");
  endtask

  initial begin
    #(2_000_000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_bounds();
    t_single();
    t_empty();
    t_bubbles();
    t_prefix();
    t_sticky();
    t_random_ranges();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule